// File: doc/BRIEF.md
# Channel-Mapped Prioritizing Interrupt Controller

This block collects a parameterized number of system interrupt inputs and presents them to a small set of host request lines. Each input is first conditioned: a per-input sense bit selects active-high/rising or active-low/falling, and a per-input mode bit selects level or edge detection. Edge inputs hold a latched status until software clears it. Level inputs report the qualified input level directly.

Routing happens in two steps. Every input is assigned to a priority channel, and every channel is assigned to a host line. A host line is raised when the global gate is open, that line's own enable is set, and at least one pending, enabled input reaches it through its channel. Software enables and disables single inputs, clears single status bits and enables single host lines by writing an index to a dedicated word. It does not write a bitmask. A read-only word reports the single winning pending input. Lower channel numbers win, and within a channel the lowest input number wins.

The register interface serves one bus master. A write takes effect at the clock edge where `wr_en` is high. Read data appears on `rdata` after the clock edge where `rd_en` is high and holds until the next read.

Top module: `chmap_intc`

## Requirements
- R1: Writing index k (k < NUM_IN) to word 0x01 enables input k, and writing it to word 0x02 disables it. An index of NUM_IN or more changes no enable. The enables read back as one bit per input at word 0x10, bit k.
- R2: Writing index k to word 0x03 clears the latched edge status of input k only. If a new active edge is detected in the same cycle as the clear, the status stays set. Status reads back at word 0x14, bit k.
- R3: The channel of input n is held in byte (n mod 4) of word 0x20 + n/4, in that byte's low CH_W bits. The upper bits of each byte read as zero.
- R4: The host line of channel c is held in byte (c mod 4) of word 0x30 + c/4, in that byte's low HOST_W bits.
- R5: Sense bits are at word 0x08 and mode bits at word 0x0C, bit n for input n. A sense bit of 1 means active high or rising edge, and 0 means active low or falling edge. A mode bit of 1 means edge and 0 means level. A level input's status equals the qualified input. An edge input's status sets on its active edge and holds.
- R6: Bit 0 of word 0x00 is the global gate. Writing host index h to word 0x04 enables host line h and writing it to word 0x05 disables it. The host enables read back at word 0x07. Output `irq_o[h]` is high only when the gate is set, line h is enabled, and a pending input (status and enable both set) reaches h through its channel.
- R7: Among pending inputs, the one on the lowest channel number wins. Within one channel, the lowest input number wins.
- R8: Word 0x06 returns the winner in bits [8:0] with bit 31 clear. When nothing is pending it returns bit 31 set and bits [8:0] all ones (0x800001FF).
- R9: After reset, all inputs, host lines and the global gate are disabled. All sense bits are 1, all mode bits are 0, all map words are 0, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_irq | input | NUM_IN | System interrupt inputs, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_o | output | NUM_HOST | Host request lines, registered |

## Verification
The two functions that can land in the same cycle are edge capture on an input and the clear-by-index write for that same input. The bench raises an edge input one cycle before issuing the clear, so the detected edge and the clear strobe meet at one clock edge. It then expects the status bit to read back as still set and the host line to stay high. A separate clear with no edge present must drop the bit, which shows that the clear works when it acts alone.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Word addresses of the register interface
  localparam logic [7:0] A_GATE    = 8'h00;
  localparam logic [7:0] A_EN_SET  = 8'h01;
  localparam logic [7:0] A_EN_CLR  = 8'h02;
  localparam logic [7:0] A_ST_CLR  = 8'h03;
  localparam logic [7:0] A_HEN_SET = 8'h04;
  localparam logic [7:0] A_HEN_CLR = 8'h05;
  localparam logic [7:0] A_WINNER  = 8'h06;
  localparam logic [7:0] A_HEN_RD  = 8'h07;
  localparam logic [7:0] A_SENSE   = 8'h08;
  localparam logic [7:0] A_MODE    = 8'h0C;
  localparam logic [7:0] A_EN_RD   = 8'h10;
  localparam logic [7:0] A_ST_RD   = 8'h14;
  localparam logic [7:0] A_CMAP    = 8'h20;
  localparam logic [7:0] A_HMAP    = 8'h30;

  localparam int unsigned WIN_W = 9;

  // Word address that holds element i when a word carries per_word elements
  function automatic logic [7:0] slot_addr(logic [7:0] base, int unsigned i,
                                           int unsigned per_word);
    return base + 8'(i / per_word);
  endfunction

  // Lowest bit of element i inside its word
  function automatic int unsigned lane_lsb(int unsigned i, int unsigned per_word);
    return (i % per_word) * (32 / per_word);
  endfunction

  // Winner word: bit 31 flags empty, low field carries the index
  function automatic logic [31:0] winner_word(logic valid, logic [WIN_W-1:0] idx);
    return valid ? {23'd0, idx} : {1'b1, 22'd0, {WIN_W{1'b1}}};
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_IN   = 16,
  parameter int NUM_CH   = 4,
  parameter int NUM_HOST = 2,
  localparam int IDX_W   = $clog2(NUM_IN),
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int HOST_W  = $clog2(NUM_HOST)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [7:0]                     addr,
  input  logic [31:0]                    wdata,
  input  logic [NUM_IN-1:0]              status_i,
  input  logic [31:0]                    winner_i,
  output logic [31:0]                    rdata,
  output logic                           gate,
  output logic [NUM_IN-1:0]              en,
  output logic [NUM_HOST-1:0]            host_en,
  output logic [NUM_IN-1:0]              sense,
  output logic [NUM_IN-1:0]              mode,
  output logic [NUM_IN-1:0][CH_W-1:0]    ch_sel,
  output logic [NUM_CH-1:0][HOST_W-1:0]  host_sel,
  output logic [NUM_IN-1:0]              clr_vec
);
  logic        idx_ok;
  logic        hidx_ok;
  logic [31:0] rd_next;

  assign idx_ok  = wdata < 32'(NUM_IN);
  assign hidx_ok = wdata < 32'(NUM_HOST);

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      clr_vec[i] = wr_en && (addr == A_ST_CLR) && (wdata == 32'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate     <= 1'b0;
      en       <= '0;
      host_en  <= '0;
      sense    <= '1;
      mode     <= '0;
      ch_sel   <= '0;
      host_sel <= '0;
    end else if (wr_en) begin
      if (addr == A_GATE) gate <= wdata[0];
      if (addr == A_EN_SET && idx_ok) en[wdata[IDX_W-1:0]] <= 1'b1;
      if (addr == A_EN_CLR && idx_ok) en[wdata[IDX_W-1:0]] <= 1'b0;
      if (addr == A_HEN_SET && hidx_ok) host_en[wdata[HOST_W-1:0]] <= 1'b1;
      if (addr == A_HEN_CLR && hidx_ok) host_en[wdata[HOST_W-1:0]] <= 1'b0;
      for (int i = 0; i < NUM_IN; i++) begin
        if (addr == slot_addr(A_SENSE, i, 32)) sense[i] <= wdata[lane_lsb(i, 32)];
        if (addr == slot_addr(A_MODE, i, 32))  mode[i]  <= wdata[lane_lsb(i, 32)];
        if (addr == slot_addr(A_CMAP, i, 4))
          ch_sel[i] <= wdata[lane_lsb(i, 4) +: CH_W];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == slot_addr(A_HMAP, c, 4))
          host_sel[c] <= wdata[lane_lsb(c, 4) +: HOST_W];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == A_GATE)   rd_next[0] = gate;
    if (addr == A_WINNER) rd_next = winner_i;
    if (addr == A_HEN_RD) rd_next[NUM_HOST-1:0] = host_en;
    for (int i = 0; i < NUM_IN; i++) begin
      if (addr == slot_addr(A_SENSE, i, 32)) rd_next[lane_lsb(i, 32)] = sense[i];
      if (addr == slot_addr(A_MODE, i, 32))  rd_next[lane_lsb(i, 32)] = mode[i];
      if (addr == slot_addr(A_EN_RD, i, 32)) rd_next[lane_lsb(i, 32)] = en[i];
      if (addr == slot_addr(A_ST_RD, i, 32)) rd_next[lane_lsb(i, 32)] = status_i[i];
      if (addr == slot_addr(A_CMAP, i, 4))
        rd_next[lane_lsb(i, 4) +: CH_W] = ch_sel[i];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == slot_addr(A_HMAP, c, 4))
        rd_next[lane_lsb(c, 4) +: HOST_W] = host_sel[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/intc_detect.sv
module intc_detect #(
  parameter int NUM_IN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] sys_irq,
  input  logic [NUM_IN-1:0] sense,
  input  logic [NUM_IN-1:0] mode,
  input  logic [NUM_IN-1:0] clr_vec,
  output logic [NUM_IN-1:0] edge_hit,
  output logic [NUM_IN-1:0] stat_edge,
  output logic [NUM_IN-1:0] status
);
  logic [NUM_IN-1:0] in_q;
  logic [NUM_IN-1:0] in_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= '0;
      in_d <= '0;
    end else begin
      in_q <= sys_irq;
      in_d <= in_q;
    end
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    logic rise, fall;
    assign rise        = in_q[g] & ~in_d[g];
    assign fall        = ~in_q[g] & in_d[g];
    assign edge_hit[g] = mode[g] & (sense[g] ? rise : fall);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_edge[g] <= 1'b0;
      else if (!mode[g]) stat_edge[g] <= 1'b0;
      else               stat_edge[g] <= (stat_edge[g] & ~clr_vec[g]) | edge_hit[g];
    end

    assign status[g] = mode[g] ? stat_edge[g] : (sense[g] ? in_q[g] : ~in_q[g]);
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_IN = 16,
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_IN),
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_IN-1:0]           pend,
  input  logic [NUM_IN-1:0][CH_W-1:0] ch_sel,
  output logic                        win_valid,
  output logic [IDX_W-1:0]            win_idx
);
  logic [CH_W-1:0] best_ch;

  // Ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best_ch   = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (pend[i] && (!win_valid || ch_sel[i] < best_ch)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best_ch   = ch_sel[i];
      end
    end
  end
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int NUM_IN   = 16,
  parameter int NUM_CH   = 4,
  parameter int NUM_HOST = 2,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int HOST_W  = $clog2(NUM_HOST)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IN-1:0]             pend,
  input  logic [NUM_IN-1:0][CH_W-1:0]   ch_sel,
  input  logic [NUM_CH-1:0][HOST_W-1:0] host_sel,
  input  logic                          gate,
  input  logic [NUM_HOST-1:0]           host_en,
  output logic [NUM_HOST-1:0]           host_req,
  output logic [NUM_HOST-1:0]           irq_o
);
  always_comb begin
    host_req = '0;
    for (int h = 0; h < NUM_HOST; h++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (pend[i] && host_sel[ch_sel[i]] == HOST_W'(h)) host_req[h] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= host_req & host_en & {NUM_HOST{gate}};
  end
endmodule

// File: rtl/chmap_intc.sv
module chmap_intc
  import intc_pkg::*;
#(
  parameter int NUM_IN   = 16,
  parameter int NUM_CH   = 4,
  parameter int NUM_HOST = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_IN-1:0]   sys_irq,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [7:0]          addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [NUM_HOST-1:0] irq_o
);
  localparam int IDX_W  = $clog2(NUM_IN);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int HOST_W = $clog2(NUM_HOST);

  logic                          gate;
  logic [NUM_IN-1:0]             en, sense, mode, clr_vec;
  logic [NUM_IN-1:0]             edge_hit, stat_edge, status, pend;
  logic [NUM_HOST-1:0]           host_en, host_req;
  logic [NUM_IN-1:0][CH_W-1:0]   ch_sel;
  logic [NUM_CH-1:0][HOST_W-1:0] host_sel;
  logic                          win_valid;
  logic [IDX_W-1:0]              win_idx;
  logic [31:0]                   winner;

  assign pend   = status & en;
  assign winner = winner_word(win_valid, WIN_W'(win_idx));

  intc_regs #(.NUM_IN(NUM_IN), .NUM_CH(NUM_CH), .NUM_HOST(NUM_HOST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status_i(status), .winner_i(winner), .rdata(rdata),
    .gate(gate), .en(en), .host_en(host_en), .sense(sense), .mode(mode),
    .ch_sel(ch_sel), .host_sel(host_sel), .clr_vec(clr_vec)
  );

  intc_detect #(.NUM_IN(NUM_IN)) u_detect (
    .clk(clk), .rst_n(rst_n), .sys_irq(sys_irq), .sense(sense), .mode(mode),
    .clr_vec(clr_vec), .edge_hit(edge_hit), .stat_edge(stat_edge), .status(status)
  );

  intc_arbiter #(.NUM_IN(NUM_IN), .NUM_CH(NUM_CH)) u_arb (
    .pend(pend), .ch_sel(ch_sel), .win_valid(win_valid), .win_idx(win_idx)
  );

  intc_route #(.NUM_IN(NUM_IN), .NUM_CH(NUM_CH), .NUM_HOST(NUM_HOST)) u_route (
    .clk(clk), .rst_n(rst_n), .pend(pend), .ch_sel(ch_sel), .host_sel(host_sel),
    .gate(gate), .host_en(host_en), .host_req(host_req), .irq_o(irq_o)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_IN   = 16,
  parameter int NUM_HOST = 2,
  localparam int IDX_W   = $clog2(NUM_IN)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                gate,
  input logic [NUM_HOST-1:0] host_en,
  input logic [NUM_HOST-1:0] irq_o,
  input logic [NUM_IN-1:0]   pend,
  input logic [NUM_IN-1:0]   mode,
  input logic [NUM_IN-1:0]   edge_hit,
  input logic [NUM_IN-1:0]   stat_edge,
  input logic [NUM_IN-1:0]   clr_vec,
  input logic                win_valid,
  input logic [IDX_W-1:0]    win_idx
);
  // R6
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_o & ~($past(host_en) & {NUM_HOST{$past(gate)}})) == '0));

  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_hit & mode) & ~stat_edge) == '0));

  // R2
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_vec & ~edge_hit) & stat_edge) == '0));

  // R2
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));

  // R7
  win_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> pend[win_idx]);

  // R8
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid == (|pend));
endmodule

bind chmap_intc intc_chk #(.NUM_IN(NUM_IN), .NUM_HOST(NUM_HOST)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .host_en(host_en), .irq_o(irq_o),
  .pend(pend), .mode(mode), .edge_hit(edge_hit), .stat_edge(stat_edge),
  .clr_vec(clr_vec), .win_valid(win_valid), .win_idx(win_idx)
);

// File: tb/chmap_intc_bench.sv
`timescale 1ns/1ps
module chmap_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sys_irq = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq_o;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fire = 1'b0;

  always #4 clk = ~clk;

  chmap_intc u_chmap_intc (
    .clk(clk), .rst_n(rst_n), .sys_irq(sys_irq), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always @(posedge clk) rd_fire <= rd_en;

  // Monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data %h", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        tests++;
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic [1:0] e, input string t);
    tests++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s: irq_o=%b expected=%b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // Reset state
    chk_irq(2'b00, "R9 irq after reset");
    rd(8'h06, 32'h8000_01FF, "R9 winner empty after reset");
    rd(8'h10, 32'h0, "R9 enables");
    rd(8'h08, 32'h0000_FFFF, "R9 sense all high");
    rd(8'h0C, 32'h0, "R9 mode all level");
    rd(8'h20, 32'h0, "R9 channel map");
    rd(8'h30, 32'h0, "R9 host map");
    rd(8'h07, 32'h0, "R9 host enables");

    // R1 index enables
    wr(8'h01, 3); wr(8'h01, 5); wr(8'h01, 20);
    rd(8'h10, 32'h28, "R1 set by index, out of range ignored");
    wr(8'h02, 3); wr(8'h02, 99);
    rd(8'h10, 32'h20, "R1 clear by index");
    wr(8'h02, 5);

    // R3 channel map, R4 host map
    wr(8'h20, 32'h0001_0203);
    rd(8'h20, 32'h0001_0203, "R3 channel bytes");
    wr(8'h21, 32'h0000_00FF);
    rd(8'h21, 32'h0000_0003, "R3 upper bits read zero");
    wr(8'h30, 32'h0100_0100);
    rd(8'h30, 32'h0100_0100, "R4 host bytes");

    // R6/R7 level routing and gating
    for (int i = 0; i < 4; i++) wr(8'h01, i);
    sys_irq[2] = 1'b1;
    wait_n(3);
    chk_irq(2'b00, "R6 gate closed");
    rd(8'h06, 32'd2, "R8 winner index");
    rd(8'h14, 32'h4, "R5 level status");
    wr(8'h00, 1); wr(8'h04, 1);
    wait_n(2);
    chk_irq(2'b10, "R6 channel1 to host1");
    sys_irq[3] = 1'b1;
    wait_n(3);
    rd(8'h06, 32'd3, "R7 lower channel wins over lower index");
    chk_irq(2'b10, "R6 host0 disabled");
    wr(8'h04, 0);
    wait_n(2);
    chk_irq(2'b11, "R6 both hosts");
    wr(8'h00, 0);
    wait_n(2);
    chk_irq(2'b00, "R6 global gate off");
    wr(8'h00, 1); wr(8'h05, 1);
    wait_n(2);
    chk_irq(2'b01, "R6 host1 cleared by index");
    rd(8'h07, 32'h1, "R6 host enable readback");

    // R7 within one channel
    wr(8'h20, 32'h0000_0101);
    sys_irq[3:0] = 4'b0011;
    wait_n(3);
    rd(8'h06, 32'd0, "R7 lowest index in channel");
    sys_irq[0] = 1'b0;
    wait_n(3);
    rd(8'h06, 32'd1, "R7 next index in channel");
    sys_irq[1] = 1'b0;

    // R5 active-low level
    wr(8'h21, 32'h0000_0002);
    wr(8'h01, 4);
    wr(8'h08, 32'h0000_FFEF);
    wait_n(3);
    rd(8'h14, 32'h10, "R5 active-low level status");
    rd(8'h06, 32'd4, "R5 active-low pending");
    sys_irq[4] = 1'b1;
    wait_n(3);
    rd(8'h06, 32'h8000_01FF, "R8 empty winner");

    // R5 edges: input 5 rising, input 6 falling
    wr(8'h0C, 32'h60);
    wr(8'h08, 32'h0000_FFAF);
    sys_irq[6] = 1'b1;
    wait_n(3);
    rd(8'h14, 32'h0, "R5 rise on falling-edge input ignored");
    sys_irq[5] = 1'b1;
    wait_n(1);
    sys_irq[5] = 1'b0;
    sys_irq[6] = 1'b0;
    wait_n(3);
    rd(8'h14, 32'h60, "R5 edges latched");
    rd(8'h06, 32'h8000_01FF, "R1 latched but disabled not pending");
    wr(8'h01, 5); wr(8'h01, 6);
    rd(8'h06, 32'd5, "R7 edge winner");
    wr(8'h03, 5);
    rd(8'h14, 32'h40, "R2 clear only input 5");
    rd(8'h06, 32'd6, "R2 other input stays");
    wr(8'h03, 6);
    rd(8'h14, 32'h0, "R2 clear input 6");

    // R2 edge and clear in the same cycle
    @(negedge clk);
    sys_irq[5] = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h03; wdata = 32'd5;
    @(negedge clk);
    wr_en = 1'b0;
    sys_irq[5] = 1'b0;
    wait_n(2);
    rd(8'h14, 32'h20, "R2 new edge wins over clear");
    chk_irq(2'b01, "R2 host stays raised");
    wr(8'h03, 5);
    wait_n(2);
    rd(8'h14, 32'h0, "R2 lone clear");
    chk_irq(2'b00, "R6 host drops after clear");

    wait_n(4);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard left %0d reads", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule